// File: doc/BRIEF.md
# SPI Flash Generic Command Shifter

This block runs one short, arbitrary transaction against a serial flash on a single-bit SPI bus. Software fills up to six transmit byte registers, writes the total number of clock cycles the transaction takes, and then writes the go bit. The engine lowers chip select, sends the transmit bytes starting with the opcode, keeps clocking for the receive phase, and shifts every sampled input bit into a bank of receive byte registers. When the last clock is done it releases chip select and clears the go bit. Software polls that bit to see the end of the transaction.

The opcode sits in the highest-indexed transmit register, and the following bytes come from lower indices in turn. Received bytes are shifted in, so the most recent byte always sits at receive index 0. The bus runs in SPI mode 0. The clock half-period is a parameter counted in system clocks.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset, chip select is high, SCK is low, the go/busy bit reads 0 and every receive byte reads 0.
- R2: Writing 1 to bit 0 at address 0 while idle, with a non-zero bit count, starts a transaction. Chip select stays low for exactly 2*HALF_DIV*count system clocks after that write edge. The go/busy bit then reads 0 again.
- R3: MOSI sends the transmit registers MSB first. It starts with register TX_BYTES-1, which holds the opcode, and continues down to register 0.
- R4: When the transmit bytes are used up, MOSI is 0 for the remaining cycles.
- R5: SCK idles low and pulses exactly count times per transaction. MOSI changes only on falling SCK edges, and MISO is sampled on rising edges.
- R6: Every sampled bit shifts into the receive bank. Receive register k holds the byte completed k bytes before the last one, so after N received bytes the first is at index N-1 and the last is at index 0.
- R7: A go write that arrives while a transaction runs is ignored. The running transaction keeps its length and its data.
- R8: A go write while the bit count is 0 is ignored. Chip select stays high and the go/busy bit reads 0.
- R9: Register map, 8-bit data: address 0 is control (bit 0 is go on write, busy on read). Address 1 is the bit count. Address 2+i is transmit byte i. Address 2+TX_BYTES+k is receive byte k, read-only. Reads are combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench uses the default parameters: HALF_DIV of 2, six transmit bytes and four receive bytes. A transaction of 64 clocks can therefore drain all six transmit bytes and still fill two receive bytes. This makes the zero-fill after the transmit bytes run out, and the receive bank ordering, both observable. A 12-cycle transaction that does not end on a byte boundary, plus go writes arriving mid-transaction and with a zero count, cover the cases where the bit count and the go bit interact.

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int HALF_DIV = 2,
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 4,
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int TXW     = 8 * TX_BYTES;
  localparam int RXW     = 8 * RX_BYTES;
  localparam int DIV_W   = $clog2(HALF_DIV + 1);
  localparam int RX_BASE = 2 + TX_BYTES;

  logic [7:0]       tx_q [TX_BYTES];
  logic [TXW-1:0]   tx_flat, tx_sh;
  logic [RXW-1:0]   rx_sh;
  logic [CNT_W-1:0] cnt_q, left_q;
  logic [DIV_W-1:0] div_q;
  logic             busy, sck_q;

  for (genvar g = 0; g < TX_BYTES; g++) begin : g_flat
    assign tx_flat[8*g +: 8] = tx_q[g];
  end

  wire go_wr = reg_wr && reg_addr == '0 && reg_wdata[0];
  wire start = go_wr && !busy && cnt_q != '0;
  wire tick  = busy && div_q == DIV_W'(HALF_DIV - 1);

  assign spi_cs_n = !busy;
  assign spi_sck  = sck_q;
  assign spi_mosi = tx_sh[TXW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TX_BYTES; i++) tx_q[i] <= '0;
      cnt_q  <= '0;
      left_q <= '0;
      div_q  <= '0;
      busy   <= 1'b0;
      sck_q  <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_W'(1)) cnt_q <= CNT_W'(reg_wdata);
      for (int i = 0; i < TX_BYTES; i++)
        if (reg_wr && reg_addr == ADDR_W'(2 + i)) tx_q[i] <= reg_wdata;
      if (start) begin
        busy   <= 1'b1;
        left_q <= cnt_q;
        tx_sh  <= tx_flat;
        div_q  <= '0;
        sck_q  <= 1'b0;
      end else if (tick) begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_sh <= {rx_sh[RXW-2:0], spi_miso};
        end else begin
          sck_q <= 1'b0;
          tx_sh <= tx_sh << 1;
          if (left_q == CNT_W'(1)) busy <= 1'b0;
          else left_q <= left_q - 1'b1;
        end
      end else if (busy) begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = {7'b0, busy};
    if (reg_addr == ADDR_W'(1)) reg_rdata = 8'(cnt_q);
    for (int i = 0; i < TX_BYTES; i++)
      if (reg_addr == ADDR_W'(2 + i)) reg_rdata = tx_q[i];
    for (int k = 0; k < RX_BYTES; k++)
      if (reg_addr == ADDR_W'(RX_BASE + k)) reg_rdata = rx_sh[8*k +: 8];
  end

  // R5
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R5
  mosi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(spi_mosi) && $past(busy)) |-> $fell(spi_sck));

  // R2
  cs_fall_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> !spi_sck);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(tick && sck_q && left_q == CNT_W'(1))) |=> busy);

  // R8
  zero_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cnt_q == '0) |=> !busy);
endmodule

// File: tb/spi_cmd_shifter_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_shifter_tb_top;
  localparam int HALF = 2;
  logic clk = 0, rst_n = 0, reg_wr = 0, spi_miso;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic spi_cs_n, spi_sck, spi_mosi;
  int checks = 0, errors = 0, exp_win = 0;
  logic [63:0] resp_vec = '0, mosi_cap = '0;
  int bidx = 0, rises = 0;

  always #2 clk = ~clk;

  spi_cmd_shifter dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // flash stub
  assign spi_miso = (bidx < 64) ? resp_vec[63-bidx] : 1'b0;
  always @(negedge spi_cs_n) begin bidx = 0; mosi_cap = '0; rises = 0; end
  always @(posedge spi_sck) begin mosi_cap = {mosi_cap[62:0], spi_mosi}; rises++; end
  always @(negedge spi_sck) bidx++;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cycle reference of the chip-select window (R2)
  always @(negedge clk) if (rst_n) begin
    if (exp_win > 0) begin chk("R2 cs_n", spi_cs_n, 0); exp_win--; end
    else chk("R2 cs_n", spi_cs_n, 1);
    if (spi_cs_n) chk("R5 idle sck", spi_sck, 0);
  end

  task automatic wr(int a, int d);
    @(negedge clk); reg_wr = 1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic go(int n, bit expect_start);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 8'h01;
    @(posedge clk); if (expect_start) exp_win = 2*HALF*n;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk); reg_addr = 4'(a); #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    while (exp_win > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic txn(logic [47:0] tx, int n, logic [63:0] resp, int rx_full);
    logic [7:0] d;
    logic [63:0] full, stream;
    for (int i = 0; i < 6; i++) wr(2+i, tx[8*i +: 8]);
    wr(1, n);
    resp_vec = resp;
    go(n, 1);
    wait_done();
    chk("R5 sck count", rises, n);
    full = {tx, 16'h0};
    chk("R3 R4 mosi bits", mosi_cap, full >> (64-n));
    rd(0, d); chk("R2 go cleared", d, 0);
    stream = resp >> (64-n);
    for (int k = 0; k < rx_full && k < 4; k++) begin
      rd(8+k, d); chk("R6 rx byte", d, stream[8*k +: 8]);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk("R1 cs_n", spi_cs_n, 1);
    chk("R1 sck", spi_sck, 0);
    rd(0, d); chk("R1 busy", d, 0);
    for (int k = 0; k < 4; k++) begin rd(8+k, d); chk("R1 rx", d, 0); end
    // R9 readback of a transmit register
    wr(7, 8'h3C); rd(7, d); chk("R9 tx5 readback", d, 8'h3C);
    // opcode then three receive bytes (R3 R6)
    txn({8'h9F, 40'h0}, 32, 64'hC2_25_39_AA_00_00_00_00, 3);
    // six transmit bytes, two receive bytes, zero fill (R4 R6)
    txn(48'hA1_B2_C3_D4_E5_F6, 64, 64'h0000_0000_0000_5A_C3, 2);
    // non byte-aligned length (R5)
    txn(48'h81_40_00_00_00_00, 12, 64'hF0F0_0000_0000_0000, 1);
    // R7: go during a running transaction is ignored
    for (int i = 0; i < 6; i++) wr(2+i, 8'h11*(i+1));
    wr(1, 16);
    resp_vec = 64'h1234_0000_0000_0000;
    go(16, 1);
    repeat (10) @(negedge clk);
    rd(0, d); chk("R7 busy mid-run", d, 1);
    go(16, 0);
    wait_done();
    chk("R7 sck count unchanged", rises, 16);
    chk("R7 mosi unchanged", mosi_cap, 64'h6655);
    rd(8, d); chk("R7 rx0", d, 8'h34);
    rd(9, d); chk("R7 rx1", d, 8'h12);
    // R8: zero count ignores go
    wr(1, 0);
    go(0, 0);
    rd(0, d); chk("R8 busy stays 0", d, 0);
    repeat (10) @(negedge clk);
    chk("R8 cs_n high", spi_cs_n, 1);
    chk("R8 no clocks", rises, 16);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule